// File: doc/BRIEF.md
# Framed Packet Transmitter

This block turns a request into one complete framed packet on a byte-wide valid/ready output. A request carries a 16-bit sequence number and a message length. The block then forwards exactly that many message bytes from a second valid/ready input.

Around the message it places a fixed ten-byte envelope. Ahead of the message go a start byte, the sequence number, the length and a token byte. After the message comes a 16-bit check value. The check value is computed on the fly as bytes leave the block.

Backpressure is handled on both sides. While the header or the check value is being sent, the message input is held off. During the message, the output's ready signal is passed straight back to the message source. The block refuses the sequence value reserved for unsolicited events. It also flags a frame whose first message byte is not a command code.

Top module: `frame_tx`

## Requirements
- R1: After reset, `req_ready` is 1 and `out_valid`, `msg_ready`, `done`, `err_seq` and `err_cmd` are 0.
- R2: The first eight bytes of a frame are, in order: 0x1B, sequence bits [7:0], sequence bits [15:8], length bits [7:0], [15:8], [23:16], [31:24], then 0x0E.
- R3: After the token, exactly `req_len` message bytes follow, unchanged and in order, then the two check bytes. A frame therefore has `req_len`+10 bytes. With `req_len` = 0 the check bytes follow the token directly.
- R4: The check value is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, with no final inversion. For each byte, the byte is XORed into bits [7:0]; then, eight times, the value shifts right by one and is XORed with 0x8408 whenever the bit shifted out was 1. It covers the eight header bytes and the message, but not itself. It is sent low byte first.
- R5: `msg_ready` stays 0 until the token byte has been accepted downstream, and stays 0 outside the message phase.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged in the next cycle (given a message source that holds its own valid data).
- R7: A request with sequence 0xFFFF is consumed and refused. `err_seq` is 1 for exactly the cycle after acceptance, no byte is sent, and `req_ready` stays 1.
- R8: When a frame's first message byte is above 0x3F, `err_cmd` is 1 for the cycle after that byte is accepted. The byte is still sent unchanged. Bytes 0x00 to 0x3F raise no flag.
- R9: `done` is a one-cycle pulse in the cycle after the high check byte is accepted. `req_ready` is 0 from acceptance of a request until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_seq | input | 16 | Sequence number of the request |
| req_len | input | 32 | Number of message bytes |
| msg_valid | input | 1 | Message byte present |
| msg_ready | output | 1 | Message byte taken |
| msg_data | input | 8 | Message byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| done | output | 1 | Frame completed pulse |
| err_seq | output | 1 | Reserved sequence refused pulse |
| err_cmd | output | 1 | Leading byte is not a command code pulse |

## Verification
Frames are sent with message lengths of zero, one, several and twenty bytes. This separates the token-to-check shortcut from normal counting of the message bytes.

Each length is paired with a different backpressure pattern: free flow, a sink that stalls often, a mostly stalled sink, and a starved source. Together these show whether bytes are lost or repeated, and whether data is held while stalled.

Leading bytes 0x3F and 0x40 sit on either side of the command-code limit, so they tell a correct bound from an off-by-one. A request with the reserved sequence, followed by a normal frame, shows that the refusal leaves the block idle and ready to work.

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int          LEN_BYTES = 4,
  parameter logic [7:0]  START     = 8'h1B,
  parameter logic [7:0]  TOKEN     = 8'h0E,
  parameter logic [7:0]  CMD_MAX   = 8'h3F,
  parameter logic [15:0] POLY      = 16'h8408,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter logic [15:0] RSV_SEQ   = 16'hFFFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [15:0]            req_seq,
  input  logic [8*LEN_BYTES-1:0] req_len,
  input  logic                   msg_valid,
  output logic                   msg_ready,
  input  logic [7:0]             msg_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   done,
  output logic                   err_seq,
  output logic                   err_cmd
);
  localparam int LEN_W     = 8 * LEN_BYTES;
  localparam int HDR_BYTES = 4 + LEN_BYTES;
  localparam int CNT_W     = $clog2(HDR_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_MSG, S_CRC} state_t;

  state_t                 state;
  logic [8*HDR_BYTES-1:0] hdr_sh;
  logic [LEN_W-1:0]       remain;
  logic [CNT_W-1:0]       cnt;
  logic [15:0]            crc;
  logic                   first;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  assign req_ready = (state == S_IDLE);
  assign msg_ready = (state == S_MSG) && out_ready;
  assign out_valid = (state == S_HDR) || (state == S_CRC) || ((state == S_MSG) && msg_valid);

  always_comb begin
    case (state)
      S_HDR:   out_data = hdr_sh[7:0];
      S_MSG:   out_data = msg_data;
      S_CRC:   out_data = (cnt == '0) ? crc[7:0] : crc[15:8];
      default: out_data = 8'h00;
    endcase
  end

  wire        fire     = out_valid && out_ready;
  wire [15:0] crc_next = crc_byte(crc, out_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      hdr_sh  <= '0;
      remain  <= '0;
      cnt     <= '0;
      crc     <= CRC_INIT;
      first   <= 1'b0;
      done    <= 1'b0;
      err_seq <= 1'b0;
      err_cmd <= 1'b0;
    end else begin
      done    <= 1'b0;
      err_seq <= 1'b0;
      err_cmd <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (req_seq == RSV_SEQ) begin
            err_seq <= 1'b1;
          end else begin
            hdr_sh <= {TOKEN, req_len, req_seq, START};
            remain <= req_len;
            cnt    <= CNT_W'(HDR_BYTES - 1);
            crc    <= CRC_INIT;
            first  <= 1'b1;
            state  <= S_HDR;
          end
        end
        S_HDR: if (fire) begin
          crc    <= crc_next;
          hdr_sh <= hdr_sh >> 8;
          if (cnt == '0) begin
            state <= (remain == '0) ? S_CRC : S_MSG;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_MSG: if (fire) begin
          crc    <= crc_next;
          remain <= remain - 1'b1;
          first  <= 1'b0;
          if (first && (msg_data > CMD_MAX)) err_cmd <= 1'b1;
          if (remain == LEN_W'(1)) begin
            state <= S_CRC;
            cnt   <= '0;
          end
        end
        S_CRC: if (fire) begin
          if (cnt == '0) begin
            cnt <= CNT_W'(1);
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk #(
  parameter int         HDR_BYTES = 8,
  parameter logic [7:0] CMD_MAX   = 8'h3F
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_seq,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [7:0]  msg_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        done,
  input logic        err_seq,
  input logic        err_cmd
);
  logic [7:0] hs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hs_cnt <= '0;
    else if (req_valid && req_ready) hs_cnt <= '0;
    else if (out_valid && out_ready && hs_cnt != 8'hFF) hs_cnt <= hs_cnt + 1'b1;
  end

  a_r5_no_early_msg: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> (hs_cnt >= 8'(HDR_BYTES)));

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_seq == 16'hFFFF) |=> (err_seq && req_ready && !out_valid));

  a_r8_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd |-> $past(msg_valid && msg_ready && (msg_data > CMD_MAX)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && $past(out_valid && out_ready)));
endmodule

bind frame_tx frame_tx_chk #(.HDR_BYTES(HDR_BYTES), .CMD_MAX(CMD_MAX)) u_chk (.*);

// File: tb/frame_tx_bench.sv
`timescale 1ns/1ps
module frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_seq = '0;
  logic [31:0] req_len = '0;
  logic        msg_valid = 1'b0, msg_ready;
  logic [7:0]  msg_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        done, err_seq, err_cmd;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  frame_tx u_frame_tx (.*);

  // fields: seq[47:32] len[31:16] first[15:8] mode[7:0]
  localparam logic [47:0] VEC [6] = '{
    {16'h0001, 16'd4,  8'h01, 8'd0},
    {16'h1234, 16'd0,  8'h00, 8'd0},
    {16'hABCD, 16'd9,  8'h3F, 8'd1},
    {16'hFFFE, 16'd5,  8'h40, 8'd2},
    {16'h8000, 16'd1,  8'hFF, 8'd3},
    {16'h0000, 16'd20, 8'h10, 8'd1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] mb(input logic [7:0] f, input int k);
    logic [7:0] t;
    if (k == 0) return f;
    t = f + 8'(13 * k);
    return t ^ 8'h5A;
  endfunction

  function automatic bit rdy(input int mode, input int c);
    case (mode)
      1: return (c % 3) != 2;
      2: return (c % 4) == 3;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit vld(input int mode, input int c);
    case (mode)
      1: return (c % 2) == 0;
      3: return (c % 5) == 4;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_frame(input logic [15:0] seq, input logic [15:0] len,
                           input logic [7:0] first, input int mode);
    logic [7:0] exp [64];
    logic [7:0] got [64];
    logic [15:0] c;
    logic [7:0] pd;
    int n, sent, last_hs, nexp, bad;
    bit pv, took, v_hold, v_early, v_busy, saw_err, saw_done, done_ok;
    n = 0; sent = 0; last_hs = -10; bad = 0;
    pv = 0; took = 0; v_hold = 0; v_early = 0; v_busy = 0; saw_err = 0; saw_done = 0; done_ok = 0;
    pd = '0;
    exp[0] = 8'h1B; exp[1] = seq[7:0]; exp[2] = seq[15:8];
    exp[3] = len[7:0]; exp[4] = len[15:8]; exp[5] = 8'h00; exp[6] = 8'h00; exp[7] = 8'h0E;
    for (int k = 0; k < int'(len); k++) exp[8+k] = mb(first, k);
    nexp = int'(len) + 10;
    c = 16'hFFFF;
    for (int k = 0; k < nexp - 2; k++) c = crc_upd(c, exp[k]);
    exp[nexp-2] = c[7:0];
    exp[nexp-1] = c[15:8];

    @(negedge clk);
    req_valid = 1'b1; req_seq = seq; req_len = {16'h0000, len};
    #1;
    check(req_ready === 1'b1, "R9 req_ready idle before request", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (took) msg_valid = 1'b0;
      took = 0;
      out_ready = rdy(mode, cyc);
      if (!msg_valid) msg_valid = (sent < int'(len)) && vld(mode, cyc);
      msg_data = mb(first, sent);
      #1;
      if (pv && (!out_valid || out_data !== pd)) v_hold = 1;
      pv = out_valid && !out_ready;
      pd = out_data;
      if (msg_ready && n < 8) v_early = 1;
      if (req_ready && !done) v_busy = 1;
      if (err_cmd) saw_err = 1;
      if (done) begin
        saw_done = 1;
        done_ok = (cyc == last_hs + 1);
        break;
      end
      if (out_valid && out_ready) begin
        if (n < 64) got[n] = out_data;
        n++;
        last_hs = cyc;
      end
      if (msg_valid && msg_ready) begin
        sent++;
        took = 1;
      end
      @(negedge clk);
    end
    msg_valid = 1'b0;
    out_ready = 1'b0;

    check(n == nexp, "R3 frame byte count", 32'(n), 32'(nexp));
    for (int k = 0; k < 8 && k < n; k++)
      if (got[k] !== exp[k]) begin
        if (bad == 0) check(1'b0, "R2 header byte", {24'h0, got[k]}, {24'h0, exp[k]});
        bad++;
      end
    if (bad == 0) check(1'b1, "R2 header", 0, 0);
    bad = 0;
    for (int k = 8; k < nexp - 2 && k < n; k++)
      if (got[k] !== exp[k]) begin
        if (bad == 0) check(1'b0, "R3 message byte", {24'h0, got[k]}, {24'h0, exp[k]});
        bad++;
      end
    if (bad == 0) check(1'b1, "R3 message", 0, 0);
    if (n == nexp)
      check({got[nexp-1], got[nexp-2]} === c, "R4 check value", {16'h0, got[nexp-1], got[nexp-2]}, {16'h0, c});
    check(!v_early, "R5 msg_ready during header", 32'(v_early), 0);
    check(!v_hold, "R6 output held while stalled", 32'(v_hold), 0);
    check(saw_done && done_ok, "R9 done one cycle after last byte", 32'(done_ok), 1);
    check(!v_busy, "R9 req_ready low while busy", 32'(v_busy), 0);
    check(saw_err == (len != 0 && first > 8'h3F), "R8 command flag", 32'(saw_err),
          32'(len != 0 && first > 8'h3F));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_ready === 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
    check({out_valid, msg_ready, done, err_seq, err_cmd} === 5'b0, "R1 outputs idle after reset",
          {27'h0, out_valid, msg_ready, done, err_seq, err_cmd}, 0);

    for (int i = 0; i < 6; i++)
      run_frame(VEC[i][47:32], VEC[i][31:16], VEC[i][15:8], int'(VEC[i][7:0]));

    @(negedge clk);
    req_valid = 1'b1; req_seq = 16'hFFFF; req_len = 32'd3;
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(err_seq === 1'b1, "R7 err_seq pulse", 32'(err_seq), 1);
    check(out_valid === 1'b0, "R7 no byte sent", 32'(out_valid), 0);
    check(req_ready === 1'b1, "R7 still ready", 32'(req_ready), 1);
    @(negedge clk);
    #1;
    check(err_seq === 1'b0, "R7 err_seq single cycle", 32'(err_seq), 0);
    check(out_valid === 1'b0, "R7 stays idle", 32'(out_valid), 0);
    out_ready = 1'b0;

    run_frame(16'h0042, 16'd3, 8'h05, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule